// File: doc/BRIEF.md
# Piecewise-Linear Sine Synthesizer

This block is a numerically controlled sine source. A 20-bit phase register advances by a programmable tuning word on every enabled clock and wraps around freely. The output frequency is therefore tuning word × clock rate / 2^20. Only the top 12 phase bits reach the amplitude stage. There, quarter-wave symmetry reduces the problem to a single quadrant.

Inside the quadrant, the sine curve is formed from eight linear pieces of equal length. Each piece is the sum of a stored intercept and at most two right-shifted copies of the in-piece offset. No lookup memory and no multiplier are used. The magnitude is rounded, given a sign from the half-cycle bit, and registered as an 11-bit two's-complement sample. The sample comes with a one-cycle-delayed valid flag. A surrounding datapath sets the tuning word and holds `en` high while it wants a sample on every clock.

Top module: `pwl_sine_synth`

## Requirements
- R1: Synchronous reset clears the phase register, `sample` and `valid` to 0. The first sample produced after reset belongs to phase 0 and equals +2.
- R2: Each clock with `en` high adds `fcw` to the 20-bit phase register, modulo 2^20. With `fcw` = 256, the sample sequence repeats every 4096 samples.
- R3: Only phase bits 19:8 feed the amplitude stage, so phase values that differ only in bits 7:0 give the same sample. With `fcw` = 255 the first samples are 2, 2, 4, 5.
- R4: Within the 12-bit phase, bit 11 is the sign, bit 10 is the mirror bit, bits 9:7 are the segment number and bits 6:0 are the offset. At offset 0 in the first quadrant, segments 0..7 give 2, 191, 384, 552, 697, 819, 909 and 971.
- R5: When bit 10 is 1, bits 9:0 are inverted bit by bit before the segment is evaluated. So phases 1023 and 1024 both give 987, and phases 3071 and 3072 both give -987.
- R6: When bit 11 is 1, the sample is the negated magnitude. The sample at phase p+2048 equals minus the sample at phase p, and it is negative exactly when bit 11 is set.
- R7: The slope of segments 0..7 is 1.5, 1.5, 1.25, 1.125, 1, 0.75, 0.5 and 0.125, each formed as one or two right shifts of 0..3 bits. Mid-segment phases 64, 192, 320, 448, 576, 704, 832 and 960 give 98, 287, 464, 624, 761, 867, 941 and 979.
- R8: The three-term sum keeps three fractional bits and is rounded half-up to an integer. Phases 1, 3, 5, 387, 391 and 900 give 4, 7, 10, 555, 560 and 972.
- R9: Every sample lies within ±8 of round(990·sin(2π(p+0.5)/4096)), where p is the 12-bit phase, and within ±1023.
- R10: With `en` low, `valid` falls on the next clock, while `sample` and the phase register hold. Enabling again resumes from the held phase.
- R11: A tuning word of 0 keeps the phase, and so the output, constant.
- R12: `valid` rises on the clock edge at which `en` is first sampled high. The sample it qualifies belongs to the phase held before that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| en | input | 1 | Advance the phase and produce a sample on this clock |
| fcw | input | 20 | Frequency tuning word added to the phase each enabled clock |
| sample | output | 11 | Signed sine sample, two's complement |
| valid | output | 1 | Sample qualifier, registered copy of `en` |

## Verification
On every cycle the assertions check the enable handshake: `valid` follows `en` one clock later, and an idle clock freezes both the sample and the phase register. They also check that a zero tuning word freezes the phase, that the sign of each sample agrees with the top phase bit it came from, and that samples stay inside the 11-bit magnitude bound. The numeric content of the curve can only be shown by the bench's scenarios. That content covers the exact intercepts and mid-segment values, the half-up rounding, the mirrored ramp in the second and fourth quadrants, the odd symmetry between the half cycles, and the closeness to a true sine across a full sweep of 4096 phases.

// File: rtl/pwl_dds_pkg.sv
package pwl_dds_pkg;

    localparam int SEG_W = 3;

    // One slope as up to two right-shifted copies of the offset
    typedef struct packed {
        logic       a_en;
        logic [1:0] a_sh;
        logic       b_en;
        logic [1:0] b_sh;
    } slope_t;

    // Intercepts in units of 1/1024 of full scale
    function automatic logic [9:0] seg_icpt(input logic [SEG_W-1:0] s);
        logic [9:0] v;
        unique case (s)
            3'd0: v = 10'd2;
            3'd1: v = 10'd191;
            3'd2: v = 10'd384;
            3'd3: v = 10'd552;
            3'd4: v = 10'd697;
            3'd5: v = 10'd819;
            3'd6: v = 10'd909;
            default: v = 10'd971;
        endcase
        return v;
    endfunction

    function automatic slope_t seg_slope(input logic [SEG_W-1:0] s);
        slope_t v;
        unique case (s)
            3'd0, 3'd1: v = '{a_en: 1'b1, a_sh: 2'd0, b_en: 1'b1, b_sh: 2'd1}; // 1.5
            3'd2:       v = '{a_en: 1'b1, a_sh: 2'd0, b_en: 1'b1, b_sh: 2'd2}; // 1.25
            3'd3:       v = '{a_en: 1'b1, a_sh: 2'd0, b_en: 1'b1, b_sh: 2'd3}; // 1.125
            3'd4:       v = '{a_en: 1'b1, a_sh: 2'd0, b_en: 1'b0, b_sh: 2'd0}; // 1
            3'd5:       v = '{a_en: 1'b1, a_sh: 2'd1, b_en: 1'b1, b_sh: 2'd2}; // 0.75
            3'd6:       v = '{a_en: 1'b1, a_sh: 2'd1, b_en: 1'b0, b_sh: 2'd0}; // 0.5
            default:    v = '{a_en: 1'b1, a_sh: 2'd3, b_en: 1'b0, b_sh: 2'd0}; // 0.125
        endcase
        return v;
    endfunction

endpackage

// File: rtl/pwl_phase_acc.sv
module pwl_phase_acc #(
    parameter int ACC_W = 20,
    parameter int PH_W  = 12
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             en,
    input  logic [ACC_W-1:0] fcw,
    output logic [ACC_W-1:0] phase_q,
    output logic [PH_W-1:0]  ph_trunc
);
    always_ff @(posedge clk) begin
        if (rst) begin
            phase_q <= '0;
        end else if (en) begin
            phase_q <= phase_q + fcw;
        end
    end

    assign ph_trunc = phase_q[ACC_W-1 -: PH_W];
endmodule

// File: rtl/pwl_quadrant_fold.sv
module pwl_quadrant_fold #(
    parameter int PH_W = 12
) (
    input  logic [PH_W-1:0]                         ph,
    output logic                                    negate,
    output logic [pwl_dds_pkg::SEG_W-1:0]           seg,
    output logic [PH_W-3-pwl_dds_pkg::SEG_W:0]      off
);
    localparam int LOW_W = PH_W - 2;

    logic [LOW_W-1:0] low;
    logic [LOW_W-1:0] folded;

    assign low    = ph[LOW_W-1:0];
    assign folded = ph[PH_W-2] ? ~low : low;
    assign seg    = folded[LOW_W-1 -: pwl_dds_pkg::SEG_W];
    assign off    = folded[LOW_W-1-pwl_dds_pkg::SEG_W:0];
    assign negate = ph[PH_W-1];
endmodule

// File: rtl/pwl_segment_eval.sv
module pwl_segment_eval #(
    parameter int OFF_W  = 7,
    parameter int FRAC_W = 3,
    parameter int MAG_W  = 10
) (
    input  logic [pwl_dds_pkg::SEG_W-1:0] seg,
    input  logic [OFF_W-1:0]              off,
    output logic [MAG_W-1:0]              mag
);
    import pwl_dds_pkg::*;

    localparam int OPW     = MAG_W + FRAC_W;
    localparam int SUM_W   = OPW + 1;
    localparam int WHOLE_W = SUM_W - FRAC_W;
    localparam int N_SH    = 4;
    localparam int MAG_MAX = (1 << MAG_W) - 1;

    logic [OPW-1:0]   base;
    logic [OPW-1:0]   shifted [N_SH];
    slope_t           sl;
    logic [OPW-1:0]   term_a;
    logic [OPW-1:0]   term_b;
    logic [OPW-1:0]   icpt_x;
    logic [SUM_W-1:0] sum;
    logic [SUM_W-1:0] rnd;
    logic [WHOLE_W-1:0] whole;

    assign base = {{(OPW-OFF_W-FRAC_W){1'b0}}, off, {FRAC_W{1'b0}}};

    for (genvar k = 0; k < N_SH; k++) begin : g_shift
        assign shifted[k] = base >> k;
    end

    always_comb begin
        sl     = seg_slope(seg);
        term_a = sl.a_en ? shifted[sl.a_sh] : '0;
        term_b = sl.b_en ? shifted[sl.b_sh] : '0;
        icpt_x = {seg_icpt(seg), {FRAC_W{1'b0}}};
        sum    = {1'b0, term_a} + {1'b0, term_b} + {1'b0, icpt_x};
        rnd    = sum + SUM_W'(1 << (FRAC_W - 1));
        whole  = rnd[SUM_W-1:FRAC_W];
        if (whole > WHOLE_W'(MAG_MAX)) begin
            mag = MAG_W'(MAG_MAX);
        end else begin
            mag = whole[MAG_W-1:0];
        end
    end
endmodule

// File: rtl/pwl_sine_synth.sv
module pwl_sine_synth #(
    parameter int ACC_W  = 20,
    parameter int PH_W   = 12,
    parameter int OUT_W  = 11,
    parameter int FRAC_W = 3
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    en,
    input  logic [ACC_W-1:0]        fcw,
    output logic signed [OUT_W-1:0] sample,
    output logic                    valid
);
    localparam int SEG_W = pwl_dds_pkg::SEG_W;
    localparam int OFF_W = PH_W - 2 - SEG_W;
    localparam int MAG_W = PH_W - 2;

    logic [ACC_W-1:0]        phase_q;
    logic [PH_W-1:0]         ph_trunc;
    logic                    negate;
    logic [SEG_W-1:0]        seg;
    logic [OFF_W-1:0]        off;
    logic [MAG_W-1:0]        mag;
    logic signed [OUT_W-1:0] mag_s;
    logic signed [OUT_W-1:0] sample_d;

    pwl_phase_acc #(.ACC_W(ACC_W), .PH_W(PH_W)) u_acc (
        .clk(clk), .rst(rst), .en(en), .fcw(fcw),
        .phase_q(phase_q), .ph_trunc(ph_trunc)
    );

    pwl_quadrant_fold #(.PH_W(PH_W)) u_fold (
        .ph(ph_trunc), .negate(negate), .seg(seg), .off(off)
    );

    pwl_segment_eval #(.OFF_W(OFF_W), .FRAC_W(FRAC_W), .MAG_W(MAG_W)) u_eval (
        .seg(seg), .off(off), .mag(mag)
    );

    always_comb begin
        mag_s    = {{(OUT_W-MAG_W){1'b0}}, mag};
        sample_d = negate ? -mag_s : mag_s;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sample <= '0;
            valid  <= 1'b0;
        end else begin
            valid <= en;
            if (en) begin
                sample <= sample_d;
            end
        end
    end
endmodule

// File: rtl/pwl_sine_synth_chk.sv
module pwl_sine_synth_chk #(
    parameter int ACC_W = 20,
    parameter int OUT_W = 11
) (
    input logic                    clk,
    input logic                    rst,
    input logic                    en,
    input logic [ACC_W-1:0]        fcw,
    input logic [ACC_W-1:0]        phase,
    input logic signed [OUT_W-1:0] sample,
    input logic                    valid
);
    localparam int LIM = (1 << (OUT_W - 1)) - 1;

    AST_VALID_AFTER_EN: assert property (@(posedge clk) disable iff (rst)
        en |=> valid); // R12
    AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (rst)
        !en |=> !valid); // R10
    AST_IDLE_FREEZE: assert property (@(posedge clk) disable iff (rst)
        !en |=> ($stable(sample) && $stable(phase))); // R10
    AST_ZERO_WORD: assert property (@(posedge clk) disable iff (rst)
        (en && fcw == '0) |=> $stable(phase)); // R11
    AST_SIGN_POS: assert property (@(posedge clk) disable iff (rst)
        (en && !phase[ACC_W-1]) |=> (sample > 0)); // R6
    AST_SIGN_NEG: assert property (@(posedge clk) disable iff (rst)
        (en && phase[ACC_W-1]) |=> (sample < 0)); // R6
    AST_MAG_BOUND: assert property (@(posedge clk) disable iff (rst)
        valid |-> (sample <= LIM && sample >= -LIM)); // R9
endmodule

bind pwl_sine_synth pwl_sine_synth_chk #(.ACC_W(ACC_W), .OUT_W(OUT_W)) u_chk (
    .clk(clk), .rst(rst), .en(en), .fcw(fcw),
    .phase(phase_q), .sample(sample), .valid(valid)
);

// File: tb/test_pwl_sine_synth.sv
`timescale 1ns/1ps
module test_pwl_sine_synth;
    logic               clk = 1'b0;
    logic               rst = 1'b1;
    logic               en  = 1'b0;
    logic [19:0]        fcw = '0;
    logic signed [10:0] sample;
    logic               valid;

    int n_chk  = 0;
    int n_fail = 0;
    int buf_s [0:4096];

    pwl_sine_synth i_pwl_sine_synth (
        .clk(clk), .rst(rst), .en(en), .fcw(fcw),
        .sample(sample), .valid(valid)
    );

    always #2 clk = ~clk;

    initial begin
        #800000;
        n_fail++;
        $display("FAIL watchdog: act=timeout exp=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d", req, act, exp);
        end
    endtask

    task automatic chk_tol(input string req, input int act, input int exp, input int tol);
        n_chk++;
        if (act > exp + tol || act < exp - tol) begin
            n_fail++;
            $display("FAIL %s: act=%0d exp=%0d+-%0d", req, act, exp, tol);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        en  = 1'b0;
        rst = 1'b1;
        @(negedge clk);
        @(negedge clk);
        rst = 1'b0;
    endtask

    // Collect n samples from the current phase, en held high
    task automatic run(input logic [19:0] word, input int n);
        fcw = word;
        en  = 1'b1;
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            buf_s[i] = int'(sample);
        end
        en = 1'b0;
    endtask

    task automatic t_reset_state();
        do_reset();
        chk("R1 valid after reset", int'(valid), 0);
        chk("R1 sample after reset", int'(sample), 0);
        // R12: valid still low until the enabling edge
        fcw = 20'd256;
        en  = 1'b1;
        #1;
        chk("R12 valid before edge", int'(valid), 0);
        @(negedge clk);
        chk("R12 valid after edge", int'(valid), 1);
        chk("R1 first sample", int'(sample), 2);
        en = 1'b0;
    endtask

    task automatic t_fine_word();
        do_reset();
        run(20'd255, 4);
        chk("R3 sample0", buf_s[0], 2);
        chk("R3 sample1", buf_s[1], 2);
        chk("R3 sample2", buf_s[2], 4);
        chk("R3 sample3", buf_s[3], 5);
    endtask

    task automatic t_full_sweep();
        int mids [8] = '{98, 287, 464, 624, 761, 867, 941, 979};
        int icpt [8] = '{2, 191, 384, 552, 697, 819, 909, 971};
        do_reset();
        run(20'd256, 4097);
        for (int p = 0; p < 4096; p++) begin
            real e;
            e = 990.0 * $sin(2.0 * 3.14159265358979 * (real'(p) + 0.5) / 4096.0);
            chk_tol("R9 accuracy", buf_s[p], int'(e), 8);
        end
        for (int p = 0; p < 2048; p++) begin
            chk("R6 odd symmetry", buf_s[p + 2048], -buf_s[p]);
        end
        for (int s = 0; s < 8; s++) begin
            chk("R4 intercept", buf_s[128 * s], icpt[s]);
            chk("R7 mid segment", buf_s[128 * s + 64], mids[s]);
        end
        chk("R5 mirror 1023", buf_s[1023], 987);
        chk("R5 mirror 1024", buf_s[1024], 987);
        chk("R5 mirror 3071", buf_s[3071], -987);
        chk("R5 mirror 3072", buf_s[3072], -987);
        chk("R8 round p1", buf_s[1], 4);
        chk("R8 round p3", buf_s[3], 7);
        chk("R8 round p5", buf_s[5], 10);
        chk("R8 round p387", buf_s[387], 555);
        chk("R8 round p391", buf_s[391], 560);
        chk("R8 round p900", buf_s[900], 972);
        chk("R2 wrap period", buf_s[4096], buf_s[0]);
    endtask

    task automatic t_hop();
        int icpt [8] = '{2, 191, 384, 552, 697, 819, 909, 971};
        do_reset();
        run(20'd32768, 8);
        for (int s = 0; s < 8; s++) begin
            chk("R2 coarse step", buf_s[s], icpt[s]);
        end
        // phase now 1024; step 1024 lands on 2048, then 3072
        run(20'd262144, 3);
        chk("R2 hop 1024", buf_s[0], 987);
        chk("R2 hop 2048", buf_s[1], -2);
        chk("R2 hop 3072", buf_s[2], -987);
    endtask

    task automatic t_hold();
        do_reset();
        run(20'd256, 5);
        chk("R10 pre-hold", buf_s[4], 8);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            chk("R10 valid low", int'(valid), 0);
            chk("R10 sample held", int'(sample), 8);
        end
        run(20'd256, 1);
        chk("R10 resume", buf_s[0], 10);
    endtask

    task automatic t_zero_word();
        do_reset();
        run(20'd0, 6);
        for (int i = 0; i < 6; i++) begin
            chk("R11 constant", buf_s[i], 2);
        end
        chk("R11 valid", int'(valid), 1);
    endtask

    initial begin
        t_reset_state();
        t_fine_word();
        t_full_sweep();
        t_hop();
        t_hold();
        t_zero_word();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule